// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block keeps a passive LCD panel refreshed from a segment bitmap. The panel is wired as a matrix of four common lines and eighteen segment lines, so up to 72 segments can be shown. It drives the matrix at quarter duty and half bias. Each pin is described by a 2-bit level code that an external analog stage turns into ground, half supply or full supply. The active common flips polarity every frame, so no net DC voltage builds up across any segment over a pair of frames.

Time slots come from a clock-enable prescaler followed by a slot counter, so the slot length (2 ms in the target system) is set by parameters for any system clock. The bitmap is copied into a shadow register only at slot boundaries. After reset, after leaving clock-stop and whenever the display is re-enabled, the block holds every LCD pin at half level for a programmable number of slots before the scan starts. A clock-stop request forces every pin to ground. A per-pin mode bit turns any common or segment pin into a plain output port driven from a latched data bit.

Top module: `lcdMuxDriver`

## Requirements
- R1: Level codes are 2'b00 ground, 2'b01 half supply and 2'b10 full supply. No pin ever shows 2'b11. `comLvl[2c+1:2c]` belongs to common c, `segLvl[2s+1:2s]` belongs to segment s, and bitmap bit `c*NUM_SEG+s` lights segment s during the slot of common c.
- R2: After reset is released, every non-port pin sits at half level for BLANK_SLOTS slots. The scan then begins with common 0 on an even frame.
- R3: During the scan exactly one common is active. It stays active for TICK_DIV*TICKS_PER_SLOT clocks, and the commons are visited in the order 0,1,…,NUM_COM-1. Inactive commons drive half level.
- R4: The active common drives full level on even frames and ground on odd frames. The frame parity toggles after the slot of the last common.
- R5: A lit segment drives the level opposite to the active common (ground versus full). An unlit segment drives the same level as the active common.
- R6: The bitmap is captured only at a slot boundary. A bitmap change inside a slot has no effect on the outputs until the next slot begins.
- R7: While `clkStop` is high, every pin drives ground from the next clock, including pins in port mode.
- R8: When `clkStop` falls, the block spends one clock stopped and then repeats the half-level blanking of R2. The scan restarts from common 0 on an even frame.
- R9: While `dispEn` is low, all non-port pins drive half level from the next clock. Scanning starts at the first slot boundary where `dispEn` is high and at least BLANK_SLOTS blank slots have passed.
- R10: A pin whose `portMode` bit is set drives full level when its `portData` bit is 1 and ground when it is 0, one clock after the inputs. This holds independently of the scan. Bit index i<NUM_COM selects common i, and index NUM_COM+s selects segment s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkStop | input | 1 | Clock-stop request; forces all pins to ground |
| dispEn | input | 1 | Display enable; low blanks the panel at half level |
| segMap | input | NUM_COM*NUM_SEG | Segment bitmap, bit c*NUM_SEG+s |
| portMode | input | NUM_COM+NUM_SEG | Per-pin plain output port select |
| portData | input | NUM_COM+NUM_SEG | Per-pin port data |
| comLvl | output | 2*NUM_COM | Common pin level codes |
| segLvl | output | 2*NUM_SEG | Segment pin level codes |

## Verification
The scan is exercised with several bitmap patterns, compared every clock against a behavioural model:
- A checkerboard tells a lit segment from an unlit one in each slot.
- A mixed pattern, observed over two frame pairs, exposes a swapped frame polarity or a swapped common order.
- Bitmap changes timed off the slot grid separate sampling at the slot boundary from sampling every clock.
- Port-mode bits with toggling data are applied while the panel scans and then during a clock-stop, which shows whether clock-stop overrides port drive.
- A display-off interval and a clock-stop release both show whether the blanking period and the restart at common 0 are honoured.

// File: rtl/lcdDrvPkg.sv
`timescale 1ns/1ps
package lcdDrvPkg;
  typedef enum logic [1:0] {
    LVL_GND  = 2'b00,
    LVL_HALF = 2'b01,
    LVL_FULL = 2'b10
  } lvl_e;

  typedef enum logic [1:0] {
    ST_STOP  = 2'b00,
    ST_BLANK = 2'b01,
    ST_SCAN  = 2'b10
  } scanSt_e;

  typedef struct packed {
    logic stopped;
    logic blank;
    logic loadMap;
    logic oddFrame;
  } scanCtl_t;
endpackage

// File: rtl/lcdScanCtrl.sv
`timescale 1ns/1ps
module lcdScanCtrl
  import lcdDrvPkg::*;
#(
  parameter int NUM_COM        = 4,
  parameter int TICK_DIV       = 200,
  parameter int TICKS_PER_SLOT = 2000,
  parameter int BLANK_SLOTS    = 1,
  localparam int COM_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkStop,
  input  logic             dispEn,
  output scanCtl_t         ctl,
  output logic [COM_W-1:0] comIdx
);
  localparam int PRE_W = $clog2(TICK_DIV + 1);
  localparam int SUB_W = $clog2(TICKS_PER_SLOT + 1);
  localparam int BLK_W = $clog2(BLANK_SLOTS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SLOT - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLANK_SLOTS - 1);
  localparam logic [COM_W-1:0] COM_LAST = COM_W'(NUM_COM - 1);

  scanSt_e          state;
  logic [PRE_W-1:0] preCnt;
  logic [SUB_W-1:0] subCnt;
  logic [BLK_W-1:0] blankCnt;
  logic             oddFrame;
  logic             tick, slotEnd, blankDone, startScan, comWrap, timerClr;

  assign tick      = (preCnt == PRE_LAST);
  assign slotEnd   = tick && (subCnt == SUB_LAST);
  assign blankDone = (blankCnt == BLK_LAST);
  assign comWrap   = (comIdx == COM_LAST);
  assign startScan = (state == ST_BLANK) && slotEnd && blankDone && dispEn && !clkStop;
  assign timerClr  = clkStop || (state == ST_STOP) || ((state == ST_SCAN) && !dispEn);

  // Two-level slot timer: clock-enable prescaler, then ticks per slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      subCnt <= '0;
    end else if (timerClr) begin
      preCnt <= '0;
      subCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
      subCnt <= (subCnt == SUB_LAST) ? '0 : subCnt + SUB_W'(1);
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  // Scan sequencing: stop, blanking, then common rotation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_BLANK;
      blankCnt <= '0;
      comIdx   <= '0;
      oddFrame <= 1'b0;
    end else if (clkStop) begin
      state <= ST_STOP;
    end else begin
      unique case (state)
        ST_STOP: begin
          state    <= ST_BLANK;
          blankCnt <= '0;
        end
        ST_BLANK: begin
          if (startScan) begin
            state    <= ST_SCAN;
            comIdx   <= '0;
            oddFrame <= 1'b0;
          end else if (slotEnd && !blankDone) begin
            blankCnt <= blankCnt + BLK_W'(1);
          end
        end
        ST_SCAN: begin
          if (!dispEn) begin
            state    <= ST_BLANK;
            blankCnt <= '0;
          end else if (slotEnd) begin
            comIdx <= comWrap ? '0 : comIdx + COM_W'(1);
            if (comWrap) oddFrame <= ~oddFrame;
          end
        end
        default: state <= ST_BLANK;
      endcase
    end
  end

  assign ctl.stopped  = (state == ST_STOP);
  assign ctl.blank    = (state == ST_BLANK);
  assign ctl.oddFrame = oddFrame;
  assign ctl.loadMap  = startScan || ((state == ST_SCAN) && dispEn && !clkStop && slotEnd);

  // R7: a stop request always lands in the stopped state
  assert_stop_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    clkStop |=> ctl.stopped);

  // R8: leaving the stopped state always passes through blanking
  assert_blank_after_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stopped && !clkStop) |=> ctl.blank);

  // R2/R8: every scan begins at common 0 on an even frame
  assert_scan_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_SCAN) |-> (comIdx == '0) && !oddFrame);

  // R3: the active common holds for the whole slot
  assert_com_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SCAN) && dispEn && !clkStop && !slotEnd) |=> $stable(comIdx) && $stable(oddFrame));
endmodule

// File: rtl/lcdLevelPath.sv
`timescale 1ns/1ps
module lcdLevelPath
  import lcdDrvPkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 18,
  localparam int COM_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1,
  localparam int NPIN   = NUM_COM + NUM_SEG,
  localparam int NMAP   = NUM_COM * NUM_SEG
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanCtl_t             ctl,
  input  logic [COM_W-1:0]     comIdx,
  input  logic [NMAP-1:0]      segMap,
  input  logic [NPIN-1:0]      portMode,
  input  logic [NPIN-1:0]      portData,
  output logic [2*NUM_COM-1:0] comLvl,
  output logic [2*NUM_SEG-1:0] segLvl
);
  logic [NMAP-1:0]    mapReg;
  logic [NPIN-1:0]    pmReg, pdReg;
  logic [NUM_SEG-1:0] rowBits;
  logic [NUM_COM-1:0] comLive;
  logic [1:0]         comNow;
  lvl_e               actLvl, oppLvl;
  logic               scanOn;

  // Shadow bitmap is refreshed only on the slot strobe; port latches every clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapReg <= '0;
      pmReg  <= '0;
      pdReg  <= '0;
    end else begin
      if (ctl.loadMap) mapReg <= segMap;
      pmReg <= portMode;
      pdReg <= portData;
    end
  end

  assign scanOn  = !ctl.stopped && !ctl.blank;
  assign actLvl  = ctl.oddFrame ? LVL_GND : LVL_FULL;
  assign oppLvl  = ctl.oddFrame ? LVL_FULL : LVL_GND;
  assign rowBits = mapReg[int'(comIdx)*NUM_SEG +: NUM_SEG];
  assign comNow  = comLvl[2*int'(comIdx) +: 2];

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    lvl_e lv;
    always_comb begin
      if (ctl.stopped)   lv = LVL_GND;
      else if (pmReg[c]) lv = pdReg[c] ? LVL_FULL : LVL_GND;
      else if (!scanOn)  lv = LVL_HALF;
      else               lv = (int'(comIdx) == c) ? actLvl : LVL_HALF;
    end
    assign comLvl[2*c +: 2] = lv;
    assign comLive[c] = !pmReg[c] && (lv != LVL_HALF);
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    lvl_e lv;
    always_comb begin
      if (ctl.stopped)             lv = LVL_GND;
      else if (pmReg[NUM_COM + s]) lv = pdReg[NUM_COM + s] ? LVL_FULL : LVL_GND;
      else if (!scanOn)            lv = LVL_HALF;
      else                         lv = rowBits[s] ? oppLvl : actLvl;
    end
    assign segLvl[2*s +: 2] = lv;

    // R5: segment level against the common pin actually driven
    assert_seg_polarity_R5: assert property (@(posedge clk) disable iff (!rstN)
      (scanOn && !pmReg[NUM_COM + s] && !pmReg[comIdx]) |->
        ((lv != LVL_HALF) && (rowBits[s] ? (lv != comNow) : (lv == comNow))));
  end

  // R3: never more than one common away from half level while scanning
  assert_one_active_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.stopped |-> ($countones(comLive) <= 1));

  // R6: bitmap shadow only moves on a slot strobe
  assert_map_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadMap |=> $stable(mapReg));
endmodule

// File: rtl/lcdMuxDriver.sv
`timescale 1ns/1ps
module lcdMuxDriver
  import lcdDrvPkg::*;
#(
  parameter int NUM_COM        = 4,
  parameter int NUM_SEG        = 18,
  parameter int TICK_DIV       = 200,
  parameter int TICKS_PER_SLOT = 2000,
  parameter int BLANK_SLOTS    = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         clkStop,
  input  logic                         dispEn,
  input  logic [NUM_COM*NUM_SEG-1:0]   segMap,
  input  logic [NUM_COM+NUM_SEG-1:0]   portMode,
  input  logic [NUM_COM+NUM_SEG-1:0]   portData,
  output logic [2*NUM_COM-1:0]         comLvl,
  output logic [2*NUM_SEG-1:0]         segLvl
);
  localparam int COM_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1;

  scanCtl_t         ctl;
  logic [COM_W-1:0] comIdx;

  lcdScanCtrl #(
    .NUM_COM(NUM_COM), .TICK_DIV(TICK_DIV),
    .TICKS_PER_SLOT(TICKS_PER_SLOT), .BLANK_SLOTS(BLANK_SLOTS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .clkStop(clkStop), .dispEn(dispEn),
    .ctl(ctl), .comIdx(comIdx)
  );

  lcdLevelPath #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .comIdx(comIdx),
    .segMap(segMap), .portMode(portMode), .portData(portData),
    .comLvl(comLvl), .segLvl(segLvl)
  );
endmodule

// File: tb/lcdMuxDriver_test.sv
`timescale 1ns/1ps
module lcdMuxDriver_test;
  localparam int NC = 4, NS = 18, TD = 2, TPS = 3, BS = 2;
  localparam int NP = NC + NS;

  logic clk = 1'b0, rstN = 1'b0, clkStop = 1'b0, dispEn = 1'b1;
  logic [NC*NS-1:0] segMap = '0;
  logic [NP-1:0] portMode = '0, portData = '0;
  logic [2*NC-1:0] comLvl;
  logic [2*NS-1:0] segLvl;

  always #2.5 clk = ~clk;

  lcdMuxDriver #(.NUM_COM(NC), .NUM_SEG(NS), .TICK_DIV(TD),
                 .TICKS_PER_SLOT(TPS), .BLANK_SLOTS(BS)) uut (
    .clk(clk), .rstN(rstN), .clkStop(clkStop), .dispEn(dispEn),
    .segMap(segMap), .portMode(portMode), .portData(portData),
    .comLvl(comLvl), .segLvl(segLvl));

  int checks = 0, errors = 0;
  string tag = "R2";
  bit done = 0;

  // Behavioural reference: 0 stopped, 1 blank, 2 scanning
  int mState = 1, mPre = 0, mSub = 0, mBlank = 0, mCom = 0;
  bit mOdd = 0;
  bit [NC*NS-1:0] mMap = '0;
  bit [NP-1:0] mPm = '0, mPd = '0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 1; mPre = 0; mSub = 0; mBlank = 0; mCom = 0; mOdd = 0;
      mMap = '0; mPm = '0; mPd = '0;
    end else begin
      bit slotEnd;
      slotEnd = (mPre == TD-1) && (mSub == TPS-1);
      mPm = portMode;
      mPd = portData;
      if (clkStop) begin
        mState = 0; mPre = 0; mSub = 0;
      end else if (mState == 0) begin
        mState = 1; mBlank = 0;
      end else if (mState == 2 && !dispEn) begin
        mState = 1; mPre = 0; mSub = 0; mBlank = 0;
      end else begin
        if (mPre == TD-1) begin
          mPre = 0;
          mSub = (mSub == TPS-1) ? 0 : mSub + 1;
        end else mPre++;
        if (slotEnd) begin
          if (mState == 1) begin
            if (mBlank >= BS-1 && dispEn) begin
              mState = 2; mCom = 0; mOdd = 0; mMap = segMap;
            end else mBlank++;
          end else begin
            mMap = segMap;
            if (mCom == NC-1) begin mCom = 0; mOdd = !mOdd; end
            else mCom++;
          end
        end
      end
    end
  end

  function automatic logic [1:0] expPin(int p);
    logic [1:0] act, opp;
    if (mState == 0) return 2'b00;
    if (mPm[p]) return mPd[p] ? 2'b10 : 2'b00;
    if (mState == 1) return 2'b01;
    act = mOdd ? 2'b00 : 2'b10;
    opp = mOdd ? 2'b10 : 2'b00;
    if (p < NC) return (p == mCom) ? act : 2'b01;
    return mMap[mCom*NS + (p-NC)] ? opp : act;
  endfunction

  task automatic checkAll();
    logic [2*NC-1:0] expC;
    logic [2*NS-1:0] expS;
    bit bad3;
    for (int p = 0; p < NC; p++) expC[2*p +: 2] = expPin(p);
    for (int s = 0; s < NS; s++) expS[2*s +: 2] = expPin(NC + s);
    checks++;
    if (comLvl !== expC || segLvl !== expS) begin
      errors++;
      $display("FAIL %s com=%h exp %h seg=%h exp %h at %0t", tag, comLvl, expC, segLvl, expS, $time);
    end
    bad3 = 0;
    for (int p = 0; p < NC; p++) if (comLvl[2*p +: 2] === 2'b11) bad3 = 1;
    for (int s = 0; s < NS; s++) if (segLvl[2*s +: 2] === 2'b11) bad3 = 1;
    checks++;
    if (bad3) begin
      errors++;
      $display("FAIL R1 code 11 seen com=%h seg=%h expected no 11", comLvl, segLvl);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      checkAll();
    end
  endtask

  initial begin
    @(negedge clk);
    tag = "R2 reset";
    checkAll();
    step(2);
    rstN = 1'b1;
    segMap = {NC*NS/2{2'b01}};
    tag = "R2"; step(14);
    tag = "R3"; step(24);
    tag = "R4"; step(24);
    segMap = {3{24'hA5C3F0}};
    tag = "R5"; step(48);
    tag = "R6";
    for (int i = 0; i < 14; i++) begin
      segMap = (72'h1 << (i*5)) ^ {9{8'(i*37)}};
      step(5);
    end
    tag = "R10";
    portMode = 22'h2A0C3;
    for (int i = 0; i < 10; i++) begin
      portData = {11{2'(i)}};
      step(3);
    end
    tag = "R7"; clkStop = 1'b1; step(10);
    tag = "R8"; clkStop = 1'b0; step(45);
    portMode = '0;
    tag = "R9"; dispEn = 1'b0; step(15);
    dispEn = 1'b1; step(45);
    dispEn = 1'b0; step(3);
    dispEn = 1'b1; step(30);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule